// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the horizontal and vertical timing of a video raster. A dot-clock enable advances a dot counter across each line and a line counter down each frame. From those counters the block derives an active-low horizontal sync, an active-low vertical sync, a display-active flag, an odd/even field flag and a one-cycle retrace pulse at every frame wrap. Line length, frame height, sync widths, display start and interlace all come from four run-time registers.

Software writes the registers through a 32-bit address/data write port. A combinational read port returns either the stored value of a register or a packed status word built from the live counters. Every register write is staged, and it moves into the working set only when a line ends. The counters therefore never see a change part way through a line.

The horizontal phase is a three-state machine: `H_SYNC`, then `H_PORCH`, then `H_SHOW`. The transitions are:
- sync to porch, when the dot count passes the sync width;
- sync to show, when the count passes both the sync width and the display start;
- porch to show, when the count passes the display start;
- any state back to `H_SYNC`, at the line end.

The vertical phase is a two-state machine with states `V_SYNC` and `V_SHOW`. It moves to `V_SHOW` at a line boundary once the new line number reaches the vertical sync length. It returns to `V_SYNC` at a line boundary where the new line number falls below that length, which happens at every frame wrap.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset the line counter, the dot counter and the field are all 0, and the status word reads 0. The registers read back their defaults: size 0x0270035F (625 lines, 864 dots), mode 0x00000000, pulse 0x0000056B (5 sync lines, 108-dot sync) and hstart 0x00000143 (display from dot 324).
- R2: The address map is size = 0, mode = 1, pulse = 2, hstart = 3 and status = 4. A write stores the data ANDed with a per-register mask: size 0x03FF03FF, mode 0x000003FF, pulse 0xFFFFFF7F and hstart 0x000003FF. The stored value reads back at the same address.
- R3: The dot counter advances only on a cycle with `dot_en` high. It wraps to 0 after size bits 9:0 plus one dots, and the line counter advances by one at that wrap.
- R4: The line counter wraps to 0 at the line end where it has reached size bits 25:16. `retrace` is high for exactly the one cycle in which the line reads 0 after that wrap.
- R5: When mode bit 4 is set, the field toggles at each frame wrap. When it is clear, the field holds its value.
- R6: Status word layout: bits 9:0 hold the line, bit 10 the field (1 = odd), bit 11 display active, bit 12 horizontal sync inactive and bit 13 vertical sync inactive. Bits 31:14 read 0.
- R7: Horizontal sync is asserted (status bit 12 = 0) for dots 0 through pulse bits 6:0 of every line.
- R8: Vertical sync is asserted (status bit 13 = 0) on every line whose number is below pulse bits 11:8.
- R9: Display active is set only on a dot above hstart bits 9:0, outside horizontal sync, and on a line that is not a vertical sync line.
- R10: A register write takes effect at the next line end. If a shortened total leaves the line counter beyond the new last line, the counter wraps to 0 at the line end that follows.
- R11: A write to the status address changes nothing. A read from an address above 4 returns 0.
- R12: `hsync_n`, `vsync_n`, `disp_active` and `field_odd` equal status bits 12, 13, 11 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot-clock enable; advances the dot counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Register value or status word (combinational) |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_active | output | 1 | Display-active flag |
| field_odd | output | 1 | Current field, 1 = odd |
| retrace | output | 1 | One-cycle pulse at frame wrap |

## Verification
A wrong dot count or horizontal state shows at the latest on the next enabled dot. It appears as a sync edge or display-active edge at the wrong position, or as a line number that steps one dot early or late. A wrong line count, vertical state or field shows in the status line bits, in `vsync_n` or in `field_odd` on the cycle after the faulty edge. A staged register that is applied at the wrong moment shows as a changed line length or height within one line.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int DW   = 32;
    localparam int AW   = 3;
    localparam int LW   = 10;
    localparam int PW   = 10;
    localparam int VW   = 4;
    localparam int SW   = 7;
    localparam int NREG = 4;
    localparam int IW   = $clog2(NREG);

    localparam logic [AW-1:0] ADR_SIZE   = 3'd0;
    localparam logic [AW-1:0] ADR_MODE   = 3'd1;
    localparam logic [AW-1:0] ADR_PULSE  = 3'd2;
    localparam logic [AW-1:0] ADR_HSTART = 3'd3;
    localparam logic [AW-1:0] ADR_STATUS = 3'd4;

    // Default timing derived from a nominal 27 MHz dot clock
    localparam int DOT_KHZ  = 27000;
    localparam int LINE_NS  = 32000;
    localparam int HSYNC_NS = 4000;
    localparam int PORCH_NS = 12000;
    localparam int DEF_LINES = 625;
    localparam int DEF_VS    = 5;
    localparam int DEF_DOTS  = DOT_KHZ * LINE_NS / 1000000;
    localparam int DEF_HSW   = DOT_KHZ * HSYNC_NS / 1000000;
    localparam int DEF_HST   = DOT_KHZ * PORCH_NS / 1000000;

    localparam int ST_FIELD  = LW;
    localparam int ST_ACTIVE = LW + 1;
    localparam int ST_HSOFF  = LW + 2;
    localparam int ST_VSOFF  = LW + 3;
    localparam int ST_USED   = LW + 4;

    typedef enum logic [1:0] {
        H_SYNC  = 2'd0,
        H_PORCH = 2'd1,
        H_SHOW  = 2'd2
    } hphase_e;

    typedef enum logic {
        V_SYNC = 1'b0,
        V_SHOW = 1'b1
    } vphase_e;

    typedef struct packed {
        logic [LW-1:0] tot_m1;
        logic [PW-1:0] len_m1;
        logic [VW-1:0] vs_lines;
        logic [SW-1:0] hsw_m1;
        logic [PW-1:0] hpos;
        logic          interlace;
    } crtc_cfg_t;

    function automatic logic [DW-1:0] reg_mask(input int idx);
        case (idx)
            0:       return 32'h03FF_03FF;
            1:       return 32'h0000_03FF;
            2:       return 32'hFFFF_FF7F;
            3:       return 32'h0000_03FF;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DW-1:0] reg_reset(input int idx);
        case (idx)
            0:       return (DW'(DEF_LINES - 1) << 16) | DW'(DEF_DOTS - 1);
            2:       return (DW'(DEF_VS) << 8) | DW'(DEF_HSW - 1);
            3:       return DW'(DEF_HST - 1);
            default: return '0;
        endcase
    endfunction

    function automatic crtc_cfg_t decode_cfg(input logic [DW-1:0] r_size,
                                             input logic [DW-1:0] r_mode,
                                             input logic [DW-1:0] r_pulse,
                                             input logic [DW-1:0] r_hstart);
        crtc_cfg_t d;
        d.tot_m1    = r_size[16 +: LW];
        d.len_m1    = r_size[0 +: PW];
        d.vs_lines  = r_pulse[8 +: VW];
        d.hsw_m1    = r_pulse[0 +: SW];
        d.hpos      = r_hstart[0 +: PW];
        d.interlace = r_mode[4];
        return d;
    endfunction

endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
    import crtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          line_end,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_reg,
    output crtc_cfg_t     cfg_act,
    output crtc_cfg_t     cfg_next
);

    logic [NREG-1:0][DW-1:0] pend_v;
    logic [NREG-1:0][DW-1:0] act_v;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] pend_q;
        logic [DW-1:0] act_q;

        // Staged copy, written by software
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= reg_reset(g);
            end else if (wr_en && (wr_addr == AW'(g))) begin
                pend_q <= wr_data & reg_mask(g);
            end
        end

        // Working copy, loaded only at a line end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q <= reg_reset(g);
            end else if (line_end) begin
                act_q <= pend_q;
            end
        end

        assign pend_v[g] = pend_q;
        assign act_v[g]  = act_q;
    end

    always_comb begin
        cfg_act  = decode_cfg(act_v[int'(ADR_SIZE)], act_v[int'(ADR_MODE)],
                              act_v[int'(ADR_PULSE)], act_v[int'(ADR_HSTART)]);
        cfg_next = line_end ?
                   decode_cfg(pend_v[int'(ADR_SIZE)], pend_v[int'(ADR_MODE)],
                              pend_v[int'(ADR_PULSE)], pend_v[int'(ADR_HSTART)]) :
                   cfg_act;
    end

    always_comb begin
        if (rd_addr < AW'(NREG)) begin
            rd_reg = pend_v[rd_addr[IW-1:0]];
        end else begin
            rd_reg = '0;
        end
    end

endmodule

// File: rtl/crtc_hphase.sv
module crtc_hphase
    import crtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dot_en,
    input  crtc_cfg_t     cfg_act,
    input  crtc_cfg_t     cfg_next,
    output logic [PW-1:0] dot,
    output logic          line_end,
    output logic          hsync_n,
    output logic          h_show
);

    hphase_e       state_q;
    hphase_e       state_d;
    logic [PW-1:0] dot_q;
    logic [PW-1:0] dot_d;
    logic          past_sync;
    logic          past_start;

    assign line_end = dot_en && (dot_q >= cfg_act.len_m1);

    always_comb begin
        if (!dot_en) begin
            dot_d = dot_q;
        end else if (line_end) begin
            dot_d = '0;
        end else begin
            dot_d = dot_q + PW'(1);
        end
    end

    assign past_sync  = dot_d > PW'(cfg_next.hsw_m1);
    assign past_start = dot_d > cfg_next.hpos;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_SYNC: begin
                if (line_end) begin
                    state_d = H_SYNC;
                end else if (dot_en && past_sync) begin
                    state_d = past_start ? H_SHOW : H_PORCH;
                end
            end
            H_PORCH: begin
                if (line_end) begin
                    state_d = H_SYNC;
                end else if (dot_en && past_start) begin
                    state_d = H_SHOW;
                end
            end
            H_SHOW: begin
                if (line_end) begin
                    state_d = H_SYNC;
                end
            end
            default: state_d = H_SYNC;
        endcase
    end

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= H_SYNC;
            dot_q   <= '0;
        end else begin
            state_q <= state_d;
            dot_q   <= dot_d;
        end
    end

    // Outputs
    always_comb begin
        hsync_n = (state_q != H_SYNC);
        h_show  = (state_q == H_SHOW);
        dot     = dot_q;
    end

endmodule

// File: rtl/crtc_vphase.sv
module crtc_vphase
    import crtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  crtc_cfg_t     cfg_act,
    input  crtc_cfg_t     cfg_next,
    output logic [LW-1:0] line,
    output logic          field_odd,
    output logic          vsync_n,
    output logic          retrace
);

    localparam vphase_e V_RESET = (DEF_VS > 0) ? V_SYNC : V_SHOW;

    vphase_e       state_q;
    vphase_e       state_d;
    logic [LW-1:0] line_q;
    logic [LW-1:0] line_d;
    logic          field_q;
    logic          retrace_q;
    logic          frame_end;
    logic          in_vs_next;

    assign frame_end = line_end && (line_q >= cfg_act.tot_m1);

    always_comb begin
        if (frame_end) begin
            line_d = '0;
        end else if (line_end) begin
            line_d = line_q + LW'(1);
        end else begin
            line_d = line_q;
        end
    end

    assign in_vs_next = line_d < LW'(cfg_next.vs_lines);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            V_SYNC: if (line_end && !in_vs_next) state_d = V_SHOW;
            V_SHOW: if (line_end && in_vs_next)  state_d = V_SYNC;
            default: state_d = V_SYNC;
        endcase
    end

    // State, counter and field register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= V_RESET;
            line_q    <= '0;
            field_q   <= 1'b0;
            retrace_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            line_q    <= line_d;
            retrace_q <= frame_end;
            if (frame_end && cfg_act.interlace) begin
                field_q <= ~field_q;
            end
        end
    end

    // Outputs
    always_comb begin
        vsync_n   = (state_q == V_SHOW);
        line      = line_q;
        field_odd = field_q;
        retrace   = retrace_q;
    end

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dot_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          disp_active,
    output logic          field_odd,
    output logic          retrace
);

    crtc_cfg_t     cfg_act;
    crtc_cfg_t     cfg_next;
    logic          line_end;
    logic [PW-1:0] dot;
    logic [LW-1:0] line;
    logic          h_show;
    logic [DW-1:0] rd_reg;
    logic [DW-1:0] status;

    crtc_regs i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .line_end (line_end),
        .rd_addr  (rd_addr),
        .rd_reg   (rd_reg),
        .cfg_act  (cfg_act),
        .cfg_next (cfg_next)
    );

    crtc_hphase i_hphase (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot_en   (dot_en),
        .cfg_act  (cfg_act),
        .cfg_next (cfg_next),
        .dot      (dot),
        .line_end (line_end),
        .hsync_n  (hsync_n),
        .h_show   (h_show)
    );

    crtc_vphase i_vphase (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_end  (line_end),
        .cfg_act   (cfg_act),
        .cfg_next  (cfg_next),
        .line      (line),
        .field_odd (field_odd),
        .vsync_n   (vsync_n),
        .retrace   (retrace)
    );

    assign disp_active = h_show && vsync_n;

    always_comb begin
        status                = '0;
        status[LW-1:0]        = line;
        status[ST_FIELD]      = field_odd;
        status[ST_ACTIVE]     = disp_active;
        status[ST_HSOFF]      = hsync_n;
        status[ST_VSOFF]      = vsync_n;
    end

    assign rd_data = (rd_addr == ADR_STATUS) ? status : rd_reg;

endmodule

// File: rtl/crtc_timing_chk.sv
module crtc_timing_chk
    import crtc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          dot_en,
    input logic [PW-1:0] dot,
    input logic [LW-1:0] line,
    input logic          line_end,
    input crtc_cfg_t     cfg_act,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          disp_active,
    input logic          field_odd,
    input logic          retrace
);

    a_r4_retrace_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        retrace |-> (line == '0 && dot == '0));

    a_r5_field_moves_on_retrace: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> retrace);

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> ($stable(dot) && $stable(line)));

    a_r10_short_total_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && line >= cfg_act.tot_m1) |=> (line == '0));

    a_r8_vsync_tracks_line: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_n == (line >= LW'(cfg_act.vs_lines)));

    a_r9_active_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
        disp_active |-> (hsync_n && vsync_n));

    a_r7_hsync_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !hsync_n);

endmodule

bind crtc_timing_gen crtc_timing_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dot_en      (dot_en),
    .dot         (dot),
    .line        (line),
    .line_end    (line_end),
    .cfg_act     (cfg_act),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .disp_active (disp_active),
    .field_odd   (field_odd),
    .retrace     (retrace)
);

// File: tb/test_crtc_timing_gen.sv
`timescale 1ns/1ps
module test_crtc_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dot_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd4;
    logic [31:0] rd_data;
    logic        hsync_n, vsync_n, disp_active, field_odd, retrace;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model of the timing, from the requirements
    int m_dot, m_line, m_field, m_retr;
    logic [31:0] p_reg [4];
    logic [31:0] a_reg [4];
    localparam logic [31:0] MASK [4] = '{32'h03FF03FF, 32'h000003FF, 32'hFFFFFF7F, 32'h000003FF};

    crtc_timing_gen i_crtc_timing_gen (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .disp_active(disp_active), .field_odd(field_odd), .retrace(retrace)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        bit hs, vs, act;
        hs  = m_dot <= int'(a_reg[2][6:0]);
        vs  = m_line < int'(a_reg[2][11:8]);
        act = !hs && !vs && (m_dot > int'(a_reg[3][9:0]));
        return {18'd0, !vs, !hs, act, m_field[0], m_line[9:0]};
    endfunction

    task automatic compare();
        logic [31:0] e;
        logic [31:0] s;
        e = exp_status();
        s = rd_data;
        check("R6 status word", s, e);
        check("R3 R10 line", {22'd0, s[9:0]}, {22'd0, e[9:0]});
        check("R5 field", {31'd0, s[10]}, {31'd0, e[10]});
        check("R9 active", {31'd0, s[11]}, {31'd0, e[11]});
        check("R7 hsync", {31'd0, s[12]}, {31'd0, e[12]});
        check("R8 vsync", {31'd0, s[13]}, {31'd0, e[13]});
        check("R12 pins", {28'd0, hsync_n, vsync_n, disp_active, field_odd},
              {28'd0, e[12], e[13], e[11], e[10]});
        check("R4 retrace", {31'd0, retrace}, m_retr);
    endtask

    task automatic step(input bit en);
        int old_tot;
        bit old_il;
        m_retr = 0;
        if (en) begin
            if (m_dot >= int'(a_reg[0][9:0])) begin
                m_dot   = 0;
                old_tot = int'(a_reg[0][25:16]);
                old_il  = a_reg[1][4];
                for (int k = 0; k < 4; k++) a_reg[k] = p_reg[k];
                if (m_line >= old_tot) begin
                    m_line = 0;
                    m_retr = 1;
                    if (old_il) m_field ^= 1;
                end else begin
                    m_line++;
                end
            end else begin
                m_dot++;
            end
        end
    endtask

    task automatic cycle(input bit en);
        @(negedge clk);
        compare();
        dot_en = en;
        @(posedge clk);
        step(en);
    endtask

    task automatic run(input int n, input int pat);
        for (int i = 0; i < n; i++) cycle((pat == 0) ? 1'b1 : ((i % pat) != pat - 1));
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        dot_en = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        step(1'b0);
        if (a < 3'd4) p_reg[a] = d & MASK[a];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
        rd_addr = 3'd4;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        m_dot = 0; m_line = 0; m_field = 0; m_retr = 0;
        p_reg[0] = 32'h0270035F; p_reg[1] = 32'h0; p_reg[2] = 32'h0000056B; p_reg[3] = 32'h00000143;
        for (int k = 0; k < 4; k++) a_reg[k] = p_reg[k];
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and default register values
        @(negedge clk);
        check("R1 reset status", rd_data, 32'h0);
        read_reg(3'd0, d); check("R1 default size", d, 32'h0270035F);
        read_reg(3'd1, d); check("R1 default mode", d, 32'h0);
        read_reg(3'd2, d); check("R1 default pulse", d, 32'h0000056B);
        read_reg(3'd3, d); check("R1 default hstart", d, 32'h00000143);

        // R2: masked stores; 7 lines of 10 dots, vsync 2, hsync 3 dots, start after dot 4, interlace
        write_reg(3'd0, 32'hFC06FC09);
        write_reg(3'd1, 32'hFFFFFC10);
        write_reg(3'd2, 32'hABCD0282);
        write_reg(3'd3, 32'hFFFF0004);
        read_reg(3'd0, d); check("R2 size mask", d, 32'h00060009);
        read_reg(3'd1, d); check("R2 mode mask", d, 32'h00000010);
        read_reg(3'd2, d); check("R2 pulse mask", d, 32'hABCD0202);
        read_reg(3'd3, d); check("R2 hstart mask", d, 32'h00000004);

        // R11: status write ignored, unused addresses read zero
        write_reg(3'd4, 32'hFFFFFFFF);
        @(negedge clk); check("R11 status after write", rd_data, exp_status());
        read_reg(3'd5, d); check("R11 unused read", d, 32'h0);
        read_reg(3'd7, d); check("R11 unused read", d, 32'h0);

        // R10: defaults stay in force until the first line end, then a full sweep
        run(3000, 4);

        // R10: shorten the frame while on line 4
        while (!(m_line == 4 && m_dot == 2)) cycle(1'b1);
        write_reg(3'd0, 32'h00020005);
        write_reg(3'd1, 32'h00000000);
        write_reg(3'd2, 32'h00000000);
        write_reg(3'd3, 32'h00000000);
        while (m_line == 4) cycle(1'b1);
        #1 check("R10 line after first boundary", {22'd0, rd_data[9:0]}, 32'd5);
        while (m_line == 5) cycle(1'b1);
        #1 check("R10 wrap after shortened total", {22'd0, rd_data[9:0]}, 32'd0);
        check("R10 R4 retrace on short wrap", {31'd0, retrace}, 32'd1);
        run(400, 3);

        // Sync wider than display start, 1 vsync line, interlace, every-cycle enable
        write_reg(3'd0, 32'h00030007);
        write_reg(3'd2, 32'h00000104);
        write_reg(3'd3, 32'h00000001);
        write_reg(3'd1, 32'h00000010);
        run(600, 0);
        run(300, 2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule